// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves fixed eight-bit characters in both directions over one serial data output and one serial data input. Both directions share a single serial clock. The clock comes from one of two sources. It can be produced inside the block by a programmable divider, in which case the block drives it onto the clock pin. It can also be taken from an external clock input, which passes through a synchronizer; the block then samples its edges in the system clock domain.

The host side looks like a small register interface. A transmit data register is loaded with a write strobe, and a receive data register is emptied with a read strobe. Separate transmit and receive enables control the two directions. Three flags report state: transmit-empty, receive-full and overrun.

Clock source and divider setting are taken only while both enables are low. With the internal clock, the line idles high and produces eight pulses per character. The exception is when receive is enabled: the clock then runs freely until receive is disabled.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Characters leave `sd_out` least-significant bit first. Each bit is driven from one falling serial clock edge to the next, so `sd_out` changes only together with a falling edge and is stable at the rising edge.
- R2: After the most significant bit of a character, `sd_out` keeps that bit's level until the next character's first falling edge.
- R3: With the internal clock (`cfg_ext_clk`=0 when configured):
  - `sck_oe`=1.
  - `sck_out` rests high when nothing is pending.
  - A transmit-only character produces exactly eight low pulses.
  - Each period is 2×(N+1) system clocks, where N is the configured `cfg_div`.
- R4: If a second character is written after the first one is loaded and before its eighth rising edge, the two characters run back to back. They produce 16 pulses with equal periods and no extra high time.
- R5: With the internal clock and `rx_en`=1, the clock keeps pulsing across character boundaries until `rx_en` is cleared. It then finishes the current pulse and stays high.
- R6: With the external clock (`cfg_ext_clk`=1 when configured), `sck_oe`=0. Transmit and receive follow the edges of `sck_in`, whose period must be at least four system clocks.
- R7: Received bits are sampled on rising serial clock edges, least-significant first. After the eighth bit, `rx_rdata` takes the character and `rx_full` is set. A one-cycle `rx_rd` clears both `rx_full` and `rx_ovr`.
- R8: If a character completes while `rx_full` is set and `rx_rd` is not asserted in that cycle, `rx_ovr` is set and `rx_rdata` keeps the older character. If `rx_rd` falls in the completion cycle, the new character is taken, `rx_full` stays set and `rx_ovr` stays clear.
- R9: When `tx_en` is low:
  - `tx_empty` reads 1 from the next cycle.
  - Any character in progress is abandoned.
  - Writes are ignored.
  - An internal clock finishes its current pulse and then produces no more.
- R10: `cfg_ext_clk` and `cfg_div` take effect only in cycles where both `tx_en` and `rx_en` are low. Changes made while either enable is high are ignored until both enables drop.
- R11: After reset: `tx_empty`=1, `rx_full`=0, `rx_ovr`=0, `sck_out`=1, `sd_out`=1 and `sck_oe`=1 (internal clock, divider 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | Clock source select: 1 = external `sck_in`, 0 = internal divider |
| cfg_div | input | DIV_W | Divider value N, serial period 2×(N+1) clocks |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_wr | input | 1 | Write strobe for the transmit data register |
| tx_wdata | input | CHAR_BITS | Character to transmit |
| rx_rd | input | 1 | Read strobe: clears receive-full and overrun |
| rx_rdata | output | CHAR_BITS | Last accepted received character |
| tx_empty | output | 1 | Transmit data register can take a character |
| rx_full | output | 1 | Receive data register holds an unread character |
| rx_ovr | output | 1 | A character was lost while the register was full |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sd_in | input | 1 | Serial data input |
| sd_out | output | 1 | Serial data output |

## Verification
Two events can land on the same system clock edge: receive completion and the host read strobe. Whether the result is an overrun depends on how they are ordered. The bench drives the external clock itself, so it knows the exact edge on which the eighth synchronized rising edge completes a character. It places `rx_rd` on that edge while an older character is still unread. The result is judged by `rx_rdata` holding the new character, `rx_full` staying high and `rx_ovr` staying low. This is compared with a separate run where the read is withheld, which must flag overrun and keep the older data.

// File: rtl/ssx_pkg.sv
`timescale 1ns/1ps
package ssx_pkg;
   // one-cycle serial clock edge events in the system clock domain
   typedef struct packed {
      logic fall;
      logic rise;
   } sck_evt_t;
endpackage

// File: rtl/ssx_sck_gen.sv
`timescale 1ns/1ps
module ssx_sck_gen
   import ssx_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_ext,
   input  logic [DIV_W-1:0] div,
   input  logic             run,
   input  logic             sck_in,
   input  logic             sd_in,
   output sck_evt_t         evt,
   output logic             sck_level,
   output logic             sd_sample
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sck_pipe;
   logic [SYNC_STAGES-1:0] sd_pipe;
   logic                   sck_last;
   logic [DIV_W-1:0]       div_cnt;
   logic                   sck_q;
   logic                   tc;
   logic                   ext_fall, ext_rise, int_fall, int_rise;

   // synchronizer stages for external clock and its data
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_pipe[0] <= 1'b1;
               sd_pipe[0]  <= 1'b1;
            end else begin
               sck_pipe[0] <= sck_in;
               sd_pipe[0]  <= sd_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_pipe[s] <= 1'b1;
               sd_pipe[s]  <= 1'b1;
            end else begin
               sck_pipe[s] <= sck_pipe[s-1];
               sd_pipe[s]  <= sd_pipe[s-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_last <= 1'b1;
      else        sck_last <= sck_pipe[TOP];
   end

   assign ext_fall = sck_last & ~sck_pipe[TOP];
   assign ext_rise = ~sck_last & sck_pipe[TOP];

   // internal divider: a started low phase always completes
   assign tc = (div_cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         sck_q   <= 1'b1;
      end else if (mode_ext || (sck_q && !run)) begin
         div_cnt <= '0;
         sck_q   <= 1'b1;
      end else if (tc) begin
         div_cnt <= '0;
         sck_q   <= ~sck_q;
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   assign int_fall = !mode_ext && sck_q && run && tc;
   assign int_rise = !mode_ext && !sck_q && tc;

   assign evt.fall  = mode_ext ? ext_fall : int_fall;
   assign evt.rise  = mode_ext ? ext_rise : int_rise;
   assign sck_level = sck_q;
   assign sd_sample = mode_ext ? sd_pipe[TOP] : sd_in;
endmodule

// File: rtl/ssx_tx.sv
`timescale 1ns/1ps
module ssx_tx
   import ssx_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          wr,
   input  logic [CW-1:0] wdata,
   input  sck_evt_t      evt,
   output logic          empty,
   output logic          pend,
   output logic          sd_out
);
   localparam int            CNT_W = $clog2(CW);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CW - 1);

   logic [CW-1:0]    tdr, sh;
   logic [CNT_W-1:0] cnt;
   logic             busy;
   logic             load;

   assign load = evt.fall && !busy && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr    <= '0;
         sh     <= '0;
         cnt    <= '0;
         busy   <= 1'b0;
         empty  <= 1'b1;
         sd_out <= 1'b1;
      end else if (!en) begin
         busy  <= 1'b0;
         cnt   <= '0;
         empty <= 1'b1;
      end else begin
         if (load) begin
            sd_out <= tdr[0];
            sh     <= tdr >> 1;
            busy   <= 1'b1;
            cnt    <= '0;
         end else if (evt.fall && busy) begin
            sd_out <= sh[0];
            sh     <= sh >> 1;
         end
         if (evt.rise && busy) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         if (wr) begin
            tdr   <= wdata;
            empty <= 1'b0;
         end else if (load) begin
            empty <= 1'b1;
         end
      end
   end

   assign pend = en && (busy || !empty);
endmodule

// File: rtl/ssx_rx.sv
`timescale 1ns/1ps
module ssx_rx
   import ssx_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          rd,
   input  sck_evt_t      evt,
   input  logic          sd,
   output logic [CW-1:0] rdata,
   output logic          full,
   output logic          ovr
);
   localparam int            CNT_W = $clog2(CW);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CW - 1);

   logic [CW-1:0]    sh, sh_n, rdata_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             full_n, ovr_n;

   always_comb begin
      sh_n    = sh;
      cnt_n   = cnt;
      rdata_n = rdata;
      full_n  = full & ~rd;
      ovr_n   = ovr & ~rd;
      if (!en) begin
         cnt_n = '0;
      end else if (evt.rise) begin
         sh_n = {sd, sh[CW-1:1]};
         if (cnt == LAST) begin
            cnt_n = '0;
            if (full_n) begin
               ovr_n = 1'b1;
            end else begin
               rdata_n = sh_n;
               full_n  = 1'b1;
            end
         end else begin
            cnt_n = cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         cnt   <= '0;
         rdata <= '0;
         full  <= 1'b0;
         ovr   <= 1'b0;
      end else begin
         sh    <= sh_n;
         cnt   <= cnt_n;
         rdata <= rdata_n;
         full  <= full_n;
         ovr   <= ovr_n;
      end
   end
endmodule

// File: rtl/sync_serial_xcvr.sv
`timescale 1ns/1ps
module sync_serial_xcvr
   import ssx_pkg::*;
#(
   parameter int CHAR_BITS   = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_ext_clk,
   input  logic [DIV_W-1:0]     cfg_div,
   input  logic                 tx_en,
   input  logic                 rx_en,
   input  logic                 tx_wr,
   input  logic [CHAR_BITS-1:0] tx_wdata,
   input  logic                 rx_rd,
   output logic [CHAR_BITS-1:0] rx_rdata,
   output logic                 tx_empty,
   output logic                 rx_full,
   output logic                 rx_ovr,
   input  logic                 sck_in,
   output logic                 sck_out,
   output logic                 sck_oe,
   input  logic                 sd_in,
   output logic                 sd_out
);
   if (CHAR_BITS < 2) begin : g_bad_char
      $error("CHAR_BITS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic             mode_ext_q;
   logic [DIV_W-1:0] div_q;
   logic             tx_pend;
   logic             run;
   logic             sck_level;
   logic             sd_sample;
   sck_evt_t         sck_ev;

   // configuration is frozen while either direction is enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_ext_q <= 1'b0;
         div_q      <= '0;
      end else if (!tx_en && !rx_en) begin
         mode_ext_q <= cfg_ext_clk;
         div_q      <= cfg_div;
      end
   end

   assign run = tx_pend || rx_en;

   ssx_sck_gen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_sck (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_ext  (mode_ext_q),
      .div       (div_q),
      .run       (run),
      .sck_in    (sck_in),
      .sd_in     (sd_in),
      .evt       (sck_ev),
      .sck_level (sck_level),
      .sd_sample (sd_sample)
   );

   ssx_tx #(.CW(CHAR_BITS)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (tx_en),
      .wr     (tx_wr),
      .wdata  (tx_wdata),
      .evt    (sck_ev),
      .empty  (tx_empty),
      .pend   (tx_pend),
      .sd_out (sd_out)
   );

   ssx_rx #(.CW(CHAR_BITS)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (rx_en),
      .rd    (rx_rd),
      .evt   (sck_ev),
      .sd    (sd_sample),
      .rdata (rx_rdata),
      .full  (rx_full),
      .ovr   (rx_ovr)
   );

   assign sck_out = mode_ext_q ? 1'b1 : sck_level;
   assign sck_oe  = ~mode_ext_q;
endmodule

// File: rtl/ssx_chk.sv
`timescale 1ns/1ps
module ssx_chk #(
   parameter int CHAR_BITS = 8,
   parameter int DIV_W     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tx_en,
   input logic                 rx_en,
   input logic                 tx_empty,
   input logic                 rx_full,
   input logic                 rx_ovr,
   input logic [CHAR_BITS-1:0] rx_rdata,
   input logic                 sck_out,
   input logic                 sck_oe,
   input logic                 sd_out,
   input logic                 fall_ev,
   input logic                 mode_ext_q,
   input logic [DIV_W-1:0]     div_q
);
   // R9
   empty_when_tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> tx_empty);

   // R10
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en || rx_en) |=> ($stable(mode_ext_q) && $stable(div_q)));

   // R1
   sd_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_ev |=> $stable(sd_out));

   // R3
   sck_parked_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && !tx_en && !rx_en && sck_out) |=> sck_out);

   // R8
   ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> ($stable(rx_rdata) && rx_full));

   // R7
   rdata_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_rdata) |-> rx_full);
endmodule

bind sync_serial_xcvr ssx_chk #(.CHAR_BITS(CHAR_BITS), .DIV_W(DIV_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_en      (tx_en),
   .rx_en      (rx_en),
   .tx_empty   (tx_empty),
   .rx_full    (rx_full),
   .rx_ovr     (rx_ovr),
   .rx_rdata   (rx_rdata),
   .sck_out    (sck_out),
   .sck_oe     (sck_oe),
   .sd_out     (sd_out),
   .fall_ev    (sck_ev.fall),
   .mode_ext_q (mode_ext_q),
   .div_q      (div_q)
);

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_ext_clk = 1'b0;
   logic [7:0] cfg_div = 8'd0;
   logic       tx_en = 1'b0, rx_en = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
   logic [7:0] tx_wdata = 8'd0;
   logic [7:0] rx_rdata;
   logic       tx_empty, rx_full, rx_ovr;
   logic       sck_in = 1'b1;
   logic       sck_out, sck_oe;
   logic       sd_in = 1'b1;
   logic       sd_out;

   always #4 clk = ~clk;

   sync_serial_xcvr u0 (
      .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div),
      .tx_en(tx_en), .rx_en(rx_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_empty(tx_empty),
      .rx_full(rx_full), .rx_ovr(rx_ovr), .sck_in(sck_in), .sck_out(sck_out),
      .sck_oe(sck_oe), .sd_in(sd_in), .sd_out(sd_out)
   );

   int checks = 0;
   int fails  = 0;

   // monitor state (internal clock line)
   int          cyc = 0, mon_fall = 0, mon_rise = 0, last_fall = 0;
   int          per_min = 1000, per_max = 0;
   logic [15:0] cap16 = '0;
   logic        glitch = 1'b0;
   logic        drive_int = 1'b0;
   logic [15:0] rx_pat = 16'h3AC5;
   logic        sck_prev = 1'b1, sd_prev = 1'b1;
   logic [7:0]  ext_cap;

   // {ext, div, tx byte, rx byte}
   localparam logic [24:0] VEC [7] = '{
      {1'b0, 8'd0, 8'hA5, 8'h00},
      {1'b0, 8'd3, 8'h3C, 8'h00},
      {1'b0, 8'd9, 8'h81, 8'h00},
      {1'b1, 8'd0, 8'h5A, 8'hC3},
      {1'b1, 8'd0, 8'hFF, 8'h00},
      {1'b1, 8'd0, 8'h01, 8'h80},
      {1'b0, 8'd1, 8'h7E, 8'h00}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic mon_reset();
      mon_fall = 0; mon_rise = 0; per_min = 1000; per_max = 0;
      cap16 = '0; glitch = 1'b0;
   endtask

   task automatic wr_tx(input logic [7:0] b);
      @(negedge clk); tx_wdata = b; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   task automatic pulse_rd();
      @(negedge clk); rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask

   // bench-driven external clock: 4 low, 4 high per bit
   task automatic ext_frame(input logic [7:0] rxb, input logic rd_last);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); sck_in = 1'b0; sd_in = rxb[i];
         repeat (4) @(negedge clk);
         sck_in = 1'b1;
         ext_cap = {sd_out, ext_cap[7:1]};
         if (rd_last && i == 7) begin
            repeat (2) @(negedge clk);
            rx_rd = 1'b1;
            @(negedge clk); rx_rd = 1'b0;
         end else begin
            repeat (3) @(negedge clk);
         end
      end
      repeat (6) @(negedge clk);
   endtask

   // line monitor for the internally generated clock
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (sck_out !== sck_prev) begin
            if (!sck_out) begin
               if (mon_fall > 0) begin
                  if (cyc - last_fall < per_min) per_min = cyc - last_fall;
                  if (cyc - last_fall > per_max) per_max = cyc - last_fall;
               end
               last_fall = cyc;
               if (drive_int) sd_in = rx_pat[mon_fall % 16];
               mon_fall++;
            end else begin
               mon_rise++;
               cap16 = {sd_out, cap16[15:1]};
            end
         end else if (sd_out !== sd_prev && sck_oe) begin
            glitch = 1'b1;
         end
         sck_prev = sck_out;
         sd_prev  = sd_out;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0]  dv, tb, rb;
      int          r;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 tx_empty", tx_empty, 1);
      chk("R11 rx_full", rx_full, 0);
      chk("R11 rx_ovr", rx_ovr, 0);
      chk("R11 sck_out", sck_out, 1);
      chk("R11 sd_out", sd_out, 1);
      chk("R11 sck_oe", sck_oe, 1);

      // vector table
      for (int v = 0; v < 7; v++) begin
         dv = VEC[v][23:16]; tb = VEC[v][15:8]; rb = VEC[v][7:0];
         cfg_ext_clk = VEC[v][24]; cfg_div = dv;
         repeat (3) @(negedge clk);
         if (!VEC[v][24]) begin
            mon_reset();
            tx_en = 1'b1;
            wr_tx(tb);
            while (mon_rise < 8) @(negedge clk);
            repeat (4 * (int'(dv) + 1) + 4) @(negedge clk);
            chk("R3 pulse count", mon_rise, 8);
            chk("R3 idle high", sck_out, 1);
            chk("R3 period", per_max, 2 * (int'(dv) + 1));
            chk("R3 period min", per_min, 2 * (int'(dv) + 1));
            chk("R1 tx data lsb first", cap16[15:8], tb);
            chk("R1 change only at fall", glitch, 0);
            chk("R2 holds msb", sd_out, tb[7]);
            tx_en = 1'b0;
         end else begin
            tx_en = 1'b1; rx_en = 1'b1;
            wr_tx(tb);
            ext_frame(rb, 1'b0);
            chk("R6 no clock drive", sck_oe, 0);
            chk("R6 ext tx data", ext_cap, tb);
            chk("R7 rx full", rx_full, 1);
            chk("R7 rx data", rx_rdata, rb);
            chk("R2 ext holds msb", sd_out, tb[7]);
            pulse_rd();
            @(negedge clk);
            chk("R7 read clears full", rx_full, 0);
            tx_en = 1'b0; rx_en = 1'b0;
         end
         @(negedge clk);
      end

      // R4 back-to-back characters
      cfg_ext_clk = 1'b0; cfg_div = 8'd2;
      repeat (3) @(negedge clk);
      mon_reset();
      tx_en = 1'b1;
      wr_tx(8'h96);
      while (mon_fall < 1) @(negedge clk);
      wr_tx(8'h0F);
      while (mon_rise < 16) @(negedge clk);
      repeat (20) @(negedge clk);
      chk("R4 pulse count", mon_rise, 16);
      chk("R4 no gap max", per_max, 6);
      chk("R4 no gap min", per_min, 6);
      chk("R4 both chars", cap16, 16'h0F96);
      tx_en = 1'b0;
      @(negedge clk);

      // R5 receive-only internal clock free-runs; R8 overrun keeps old data
      cfg_div = 8'd1;
      repeat (3) @(negedge clk);
      mon_reset();
      drive_int = 1'b1;
      rx_en = 1'b1;
      while (mon_rise < 20) @(negedge clk);
      chk("R5 clock keeps running", mon_rise > 8, 1);
      chk("R7 int rx data", rx_rdata, 8'hC5);
      chk("R8 overrun flag", rx_ovr, 1);
      chk("R8 full stays", rx_full, 1);
      rx_en = 1'b0;
      repeat (10) @(negedge clk);
      r = mon_rise;
      repeat (30) @(negedge clk);
      chk("R5 stops after rx off", mon_rise, r);
      chk("R5 parks high", sck_out, 1);
      drive_int = 1'b0;
      pulse_rd();
      @(negedge clk);
      chk("R7 read clears full", rx_full, 0);
      chk("R7 read clears overrun", rx_ovr, 0);

      // R8 read in the completion cycle (external clock)
      cfg_ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      rx_en = 1'b1;
      ext_frame(8'h11, 1'b0);
      ext_frame(8'h22, 1'b1);
      chk("R8 same-cycle read takes new", rx_rdata, 8'h22);
      chk("R8 same-cycle read full", rx_full, 1);
      chk("R8 same-cycle read no overrun", rx_ovr, 0);
      ext_frame(8'h33, 1'b0);
      chk("R8 overrun ext", rx_ovr, 1);
      chk("R8 old data kept", rx_rdata, 8'h22);
      pulse_rd();
      rx_en = 1'b0;
      @(negedge clk);

      // R9 transmit disable mid-character, writes while disabled
      cfg_ext_clk = 1'b0; cfg_div = 8'd3;
      repeat (3) @(negedge clk);
      mon_reset();
      tx_en = 1'b1;
      wr_tx(8'hF0);
      while (mon_fall < 2) @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk("R9 empty after disable", tx_empty, 1);
      repeat (30) @(negedge clk);
      chk("R9 no further pulses", mon_rise, 2);
      chk("R9 clock high", sck_out, 1);
      wr_tx(8'hAA);
      chk("R9 write ignored", tx_empty, 1);
      tx_en = 1'b1;
      r = mon_fall;
      repeat (40) @(negedge clk);
      chk("R9 nothing sent", mon_fall, r);
      tx_en = 1'b0;
      @(negedge clk);

      // R10 configuration frozen while enabled
      cfg_div = 8'd1;
      repeat (3) @(negedge clk);
      mon_reset();
      tx_en = 1'b1;
      wr_tx(8'h55);
      while (mon_fall < 2) @(negedge clk);
      cfg_div = 8'd20; cfg_ext_clk = 1'b1;
      while (mon_rise < 8) @(negedge clk);
      repeat (12) @(negedge clk);
      chk("R10 period unchanged", per_max, 4);
      chk("R10 source unchanged", sck_oe, 1);
      chk("R10 data intact", cap16[15:8], 8'h55);
      tx_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R10 taken when idle", sck_oe, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule